// File: doc/BRIEF.md
# Command-Response Buffer Control Sequencer

This block runs the control area of a shared-buffer interface to a secure device. Software puts a command into a data buffer outside this block, then uses a few control registers here to move the device between its states: idle, ready, command execution and command completion. Software asks for ready and idle by setting request bits, and the device clears each bit to acknowledge it. A start doorbell launches a command, and the device clears that doorbell when the command finishes. A cancel flag lets software ask the execution engine to abandon a running command.

Each ready or idle transition needs an acknowledgement from the device's back end. The block raises a request toward the back end and counts the cycles until it answers. If no answer arrives within a parameterised number of cycles, the block records a sticky fatal error and takes no further requests. A handshake with an execution-engine stub reports busy and abort. A completion event sets an interrupt status bit that software clears by writing 1. The interrupt line is that status bit gated by an enable bit.

Top module: `crb_ctrl_top`

## Requirements
- R1: After reset the block is idle. The status word at word address 1 reads 2 (bit 1 idle = 1, bit 0 fatal = 0). Every other register reads 0, and transReq, execBusy, execAbort and irq are 0.
- R2: Writing a word with bit 0 set to address 0 sets the ready request (read back as bit 0). While it is pending, transReq is 1 and transToIdle is 0. A cycle with transAck = 1 moves the device to ready, clears bit 0 and clears status bit 1. Writing 0 to a request bit has no effect.
- R3: Writing a word with bit 1 set to address 0 sets the idle request (bit 1). When transAck arrives in any state other than execution, the device enters idle, clears bit 1 and sets status bit 1. If both request bits are pending, the idle request is served first (transToIdle = 1). During execution transReq stays 0, so a request waits until completion.
- R4: A pending request may be acknowledged in any of its first TIMEOUT_CYCLES cycles. If it is not, the fatal bit (status bit 0) is set at the end of the last of those cycles, both request bits clear and the state stays where it was. Fatal is cleared only by reset. While fatal is set, transReq stays 0 and start writes are ignored.
- R5: Writing the word 1 to address 3 while ready, with no request pending and no fatal error, enters execution. In the next cycle execBusy = 1 and address 3 reads 1. Start writes in any other state, and writes of any other value, are ignored.
- R6: execDone during execution enters completion, clears address 3 to 0 and sets interrupt status (address 5 bit 0). execDone outside execution is ignored. From completion, a ready request returns to ready and an idle request returns to idle.
- R7: Writing the word 1 to address 2 sets the cancel flag and writing 0 clears it. Other values are ignored. Address 2 reads the flag, and execAbort is the flag while execBusy is 1.
- R8: Address 4 bit 0 is the interrupt enable and is written directly. Writing bit 0 = 1 to address 5 clears interrupt status, but a completion in the same cycle wins. irq equals status AND enable.
- R9: Addresses 6 and 7 and all unlisted bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Single-cycle register write strobe |
| regAddr | input | ADDR_W | Register word address for reads and writes |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr (combinational) |
| transReq | output | 1 | Ready/idle transition request to the back end |
| transToIdle | output | 1 | 1 when the pending transition targets idle |
| transAck | input | 1 | Back-end acknowledgement of the transition |
| execBusy | output | 1 | Command execution in progress |
| execAbort | output | 1 | Cancel requested for the running command |
| execDone | input | 1 | Execution engine reports the response is written |
| irq | output | 1 | Interrupt line |

## Verification
The properties assume that register writes are single-cycle strobes. They also assume that the back end may raise transAck or execDone in any cycle, wanted or not, and that the block must simply ignore such pulses when nothing is pending. The stimulus respects this. It mixes directed sequences with random cycles in which writes target every address with small and arbitrary words, and in which acknowledge and done pulses fire at random, including in states where they must have no effect. Acknowledges are frequent in the random phase so that a timeout is unlikely there. The timeout and its boundary cycle are exercised separately after a fresh reset.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;

  // Word addresses of the control registers
  localparam int REG_REQUEST = 0;
  localparam int REG_STATUS  = 1;
  localparam int REG_CANCEL  = 2;
  localparam int REG_START   = 3;
  localparam int REG_INT_EN  = 4;
  localparam int REG_INT_STS = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } crbState_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic ackReady;     // ready transition acknowledged
    logic ackIdle;      // idle transition acknowledged
    logic timeoutHit;   // acknowledgement window expired
    logic acceptStart;  // start doorbell accepted
    logic execFinish;   // execution completed
  } ctlStrobes_t;

endpackage

// File: rtl/crb_datapath.sv
`timescale 1ns/1ps
module crb_datapath #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  output logic [DATA_W-1:0]       regRdData,
  input  crb_pkg::ctlStrobes_t    strb,
  input  logic                    inIdle,
  input  logic                    execBusy,
  output logic                    wantReady,
  output logic                    wantIdle,
  output logic                    fatal,
  output logic                    startWr1,
  output logic                    execAbort,
  output logic                    irq
);
  import crb_pkg::*;

  localparam logic [DATA_W-1:0] WORD_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] WORD_ZERO = '0;

  logic wantReadyQ, wantIdleQ, startQ, cancelQ, intEnQ, intStsQ, fatalQ;
  logic hitRequest, hitCancel, hitStart, hitIntEn, hitIntSts;
  logic clrReady, clrIdle;

  always_comb begin
    hitRequest = regWrEn && (regAddr == ADDR_W'(REG_REQUEST));
    hitCancel  = regWrEn && (regAddr == ADDR_W'(REG_CANCEL));
    hitStart   = regWrEn && (regAddr == ADDR_W'(REG_START));
    hitIntEn   = regWrEn && (regAddr == ADDR_W'(REG_INT_EN));
    hitIntSts  = regWrEn && (regAddr == ADDR_W'(REG_INT_STS));
    clrReady   = strb.ackReady | strb.timeoutHit;
    clrIdle    = strb.ackIdle  | strb.timeoutHit;
  end

  assign startWr1 = hitStart && (regWrData == WORD_ONE);

  // Software-set request bits, self-cleared by the device
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wantReadyQ <= 1'b0;
      wantIdleQ  <= 1'b0;
    end else begin
      wantReadyQ <= (wantReadyQ | (hitRequest & regWrData[0])) & ~clrReady;
      wantIdleQ  <= (wantIdleQ  | (hitRequest & regWrData[1])) & ~clrIdle;
    end
  end

  // Sticky fatal error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fatalQ <= 1'b0;
    else if (strb.timeoutHit) fatalQ <= 1'b1;
  end

  // Start doorbell: set on acceptance, cleared by completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startQ <= 1'b0;
    else if (strb.acceptStart) startQ <= 1'b1;
    else if (strb.execFinish) startQ <= 1'b0;
  end

  // Cancel flag: whole-word 1 sets, whole-word 0 clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cancelQ <= 1'b0;
    else if (hitCancel && (regWrData == WORD_ONE)) cancelQ <= 1'b1;
    else if (hitCancel && (regWrData == WORD_ZERO)) cancelQ <= 1'b0;
  end

  // Interrupt enable and write-1-to-clear status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ  <= 1'b0;
      intStsQ <= 1'b0;
    end else begin
      if (hitIntEn) intEnQ <= regWrData[0];
      if (strb.execFinish) intStsQ <= 1'b1;
      else if (hitIntSts && regWrData[0]) intStsQ <= 1'b0;
    end
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_W'(REG_REQUEST): regRdData[1:0] = {wantIdleQ, wantReadyQ};
      ADDR_W'(REG_STATUS):  regRdData[1:0] = {inIdle, fatalQ};
      ADDR_W'(REG_CANCEL):  regRdData[0]   = cancelQ;
      ADDR_W'(REG_START):   regRdData[0]   = startQ;
      ADDR_W'(REG_INT_EN):  regRdData[0]   = intEnQ;
      ADDR_W'(REG_INT_STS): regRdData[0]   = intStsQ;
      default:              regRdData      = '0;
    endcase
  end

  assign wantReady = wantReadyQ;
  assign wantIdle  = wantIdleQ;
  assign fatal     = fatalQ;
  assign execAbort = cancelQ & execBusy;
  assign irq       = intStsQ & intEnQ;

endmodule

// File: rtl/crb_control.sv
`timescale 1ns/1ps
module crb_control #(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wantReady,
  input  logic                  wantIdle,
  input  logic                  fatal,
  input  logic                  startWr1,
  input  logic                  transAck,
  input  logic                  execDone,
  output crb_pkg::ctlStrobes_t  strb,
  output logic                  transReq,
  output logic                  transToIdle,
  output logic                  execBusy,
  output logic                  inIdle
);
  import crb_pkg::*;

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  crbState_t        stateQ, stateD;
  logic [TMR_W-1:0] timerQ;

  always_comb begin
    transReq    = !fatal && (stateQ != ST_EXEC) && (wantReady || wantIdle);
    transToIdle = transReq && wantIdle;

    strb.ackIdle     = transReq && transAck && wantIdle;
    strb.ackReady    = transReq && transAck && !wantIdle;
    strb.timeoutHit  = transReq && !transAck && (timerQ == TMR_LAST);
    strb.acceptStart = startWr1 && (stateQ == ST_READY) && !transReq && !fatal;
    strb.execFinish  = (stateQ == ST_EXEC) && execDone;
  end

  always_comb begin
    stateD = stateQ;
    if (strb.ackIdle)          stateD = ST_IDLE;
    else if (strb.ackReady)    stateD = ST_READY;
    else if (strb.acceptStart) stateD = ST_EXEC;
    else if (strb.execFinish)  stateD = ST_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // Acknowledgement window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerQ <= '0;
    else if (!transReq || transAck || strb.timeoutHit) timerQ <= '0;
    else timerQ <= timerQ + 1'b1;
  end

  assign execBusy = (stateQ == ST_EXEC);
  assign inIdle   = (stateQ == ST_IDLE);

endmodule

// File: rtl/crb_ctrl_top.sv
`timescale 1ns/1ps
module crb_ctrl_top #(
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              transReq,
  output logic              transToIdle,
  input  logic              transAck,
  output logic              execBusy,
  output logic              execAbort,
  input  logic              execDone,
  output logic              irq
);
  import crb_pkg::*;

  ctlStrobes_t strb;
  logic wantReady, wantIdle, fatalFlag, startWr1, inIdle;

  crb_control #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .wantReady(wantReady), .wantIdle(wantIdle), .fatal(fatalFlag),
    .startWr1(startWr1), .transAck(transAck), .execDone(execDone),
    .strb(strb), .transReq(transReq), .transToIdle(transToIdle),
    .execBusy(execBusy), .inIdle(inIdle)
  );

  crb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strb(strb), .inIdle(inIdle),
    .execBusy(execBusy), .wantReady(wantReady), .wantIdle(wantIdle),
    .fatal(fatalFlag), .startWr1(startWr1), .execAbort(execAbort), .irq(irq)
  );

endmodule

// File: rtl/crb_ctrl_checker.sv
`timescale 1ns/1ps
module crb_ctrl_checker #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              transReq,
  input logic              execBusy,
  input logic              execDone,
  input logic              execAbort,
  input logic              irq,
  input logic              fatalFlag
);
  import crb_pkg::*;

  a_r5_start_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(execBusy) |-> $past(regWrEn && (regAddr == ADDR_W'(REG_START)) && (regWrData == DATA_W'(1))));

  a_r6_done_ends_exec: assert property (@(posedge clk) disable iff (!rstN)
    (execBusy && execDone) |=> !execBusy);

  a_r3_no_trans_in_exec: assert property (@(posedge clk) disable iff (!rstN)
    transReq |-> !execBusy);

  a_r4_fatal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fatalFlag |=> fatalFlag);

  a_r4_fatal_blocks_req: assert property (@(posedge clk) disable iff (!rstN)
    fatalFlag |-> !transReq);

  a_r7_abort_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    execAbort |-> execBusy);

  a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(execBusy && execDone) ||
                    $past(regWrEn && (regAddr == ADDR_W'(REG_INT_EN)) && regWrData[0])));

endmodule

bind crb_ctrl_top crb_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .transReq(transReq), .execBusy(execBusy),
  .execDone(execDone), .execAbort(execAbort), .irq(irq), .fatalFlag(fatalFlag)
);

// File: tb/sim_crb_ctrl_top.sv
`timescale 1ns/1ps
module sim_crb_ctrl_top;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int TO     = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic transAck = 1'b0;
  logic execDone = 1'b0;
  logic [DATA_W-1:0] regRdData;
  logic transReq, transToIdle, execBusy, execAbort, irq;

  crb_ctrl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .transReq(transReq),
    .transToIdle(transToIdle), .transAck(transAck), .execBusy(execBusy),
    .execAbort(execAbort), .execDone(execDone), .irq(irq)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // Reference model (states: 0 idle, 1 ready, 2 exec, 3 done)
  int mState, mTimer;
  bit mWantR, mWantI, mStart, mCancel, mIntEn, mIntSts, mFatal;

  function automatic bit expTransReq();
    return !mFatal && (mState != 2) && (mWantR || mWantI);
  endfunction

  function automatic logic [DATA_W-1:0] expRead(int a);
    case (a)
      0: return DATA_W'({mWantI, mWantR});
      1: return DATA_W'({(mState == 0), mFatal});
      2: return DATA_W'(mCancel);
      3: return DATA_W'(mStart);
      4: return DATA_W'(mIntEn);
      5: return DATA_W'(mIntSts);
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(int a);
    case (a)
      0: return "R2 request reg";
      1: return "R4 status reg";
      2: return "R7 cancel reg";
      3: return "R5 start reg";
      4: return "R8 int enable";
      5: return "R6 int status";
      default: return "R9 unused addr";
    endcase
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mState = 0; mTimer = 0;
    mWantR = 0; mWantI = 0; mStart = 0; mCancel = 0;
    mIntEn = 0; mIntSts = 0; mFatal = 0;
  endtask

  task automatic modelStep(bit we, int a, logic [DATA_W-1:0] d, bit ack, bit done);
    bit tr, clrR, clrI, accept, fin;
    int nState;
    tr = expTransReq();
    clrR = 0; clrI = 0; nState = mState;
    if (tr) begin
      if (ack) begin
        if (mWantI) begin nState = 0; clrI = 1; end
        else begin nState = 1; clrR = 1; end
        mTimer = 0;
      end else if (mTimer == TO - 1) begin
        mFatal = 1; clrR = 1; clrI = 1; mTimer = 0;
      end else mTimer++;
    end else mTimer = 0;
    accept = we && (a == 3) && (d == 1) && (mState == 1) && !tr && !mFatal;
    fin = (mState == 2) && done;
    if (accept) begin nState = 2; mStart = 1; end
    if (fin) begin nState = 3; mStart = 0; end
    if (we && a == 0) begin mWantR = mWantR | d[0]; mWantI = mWantI | d[1]; end
    if (clrR) mWantR = 0;
    if (clrI) mWantI = 0;
    if (we && a == 2 && d == 1) mCancel = 1;
    else if (we && a == 2 && d == 0) mCancel = 0;
    if (we && a == 4) mIntEn = d[0];
    if (fin) mIntSts = 1;
    else if (we && a == 5 && d[0]) mIntSts = 0;
    mState = nState;
  endtask

  // Called right after a falling edge with no write pending
  task automatic checkAll();
    regWrEn = 1'b0;
    for (int a = 0; a < 8; a++) begin
      regAddr = ADDR_W'(a);
      #0.25;
      check(tagFor(a), regRdData, expRead(a));
    end
    check("R3 transReq", DATA_W'(transReq), DATA_W'(expTransReq()));
    check("R3 transToIdle", DATA_W'(transToIdle), DATA_W'(expTransReq() && mWantI));
    check("R5 execBusy", DATA_W'(execBusy), DATA_W'(mState == 2));
    check("R7 execAbort", DATA_W'(execAbort), DATA_W'(mCancel && mState == 2));
    check("R8 irq", DATA_W'(irq), DATA_W'(mIntSts && mIntEn));
  endtask

  task automatic step(bit we, int a, logic [DATA_W-1:0] d, bit ack, bit done);
    @(negedge clk);
    checkAll();
    regWrEn = we; regAddr = ADDR_W'(a); regWrData = d;
    transAck = ack; execDone = done;
    modelStep(we, a, d, ack, done);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 0; transAck = 0; execDone = 0; regWrData = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nErrors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    // R1 explicit reset state
    regAddr = ADDR_W'(1); #0.25;
    check("R1 status after reset", regRdData, DATA_W'(2));
    check("R1 busy after reset", DATA_W'(execBusy), '0);
    check("R1 irq after reset", DATA_W'(irq), '0);
    check("R1 transReq after reset", DATA_W'(transReq), '0);

    step(1, 3, 1, 0, 0);           // R5 start in idle ignored
    step(1, 0, 0, 1, 0);           // R2 writing 0 no effect, ack ignored
    step(1, 0, 1, 0, 0);           // R2 ready request
    step(0, 0, 0, 0, 0);           // pending
    step(0, 0, 0, 1, 0);           // R2 ack -> ready
    step(1, 3, 0, 0, 0);           // R5 write 0 ignored
    step(1, 3, 3, 0, 0);           // R5 other value ignored
    step(1, 4, 1, 0, 0);           // R8 enable
    step(1, 3, 1, 0, 0);           // R5 start
    step(1, 2, 1, 0, 0);           // R7 cancel -> abort
    step(1, 2, 5, 0, 0);           // R7 other value ignored
    step(1, 0, 2, 0, 0);           // R3 go-idle during exec held
    step(0, 0, 0, 1, 0);           // R3 ack ignored in exec
    step(0, 0, 0, 0, 1);           // R6 completion
    step(1, 3, 1, 0, 1);           // R6 start/done ignored in done
    step(1, 5, 1, 0, 0);           // R8 W1C
    step(1, 2, 0, 0, 0);           // R7 clear cancel
    step(0, 0, 0, 1, 0);           // R3 ack -> idle
    step(1, 0, 3, 0, 0);           // R3 both requests
    step(0, 0, 0, 1, 0);           // R3 idle served first
    step(0, 0, 0, 1, 0);           // R2 then ready
    step(1, 3, 1, 0, 0);           // start
    step(1, 5, 1, 0, 1);           // R8 completion wins over clear
    step(1, 0, 1, 0, 0);           // R6 ready from done
    step(0, 0, 0, 1, 0);
    idle(2);

    // Random phase
    for (int i = 0; i < 300; i++) begin
      int a, sel;
      logic [DATA_W-1:0] d;
      a = int'($urandom % 8);
      sel = int'($urandom % 6);
      d = (sel < 4) ? DATA_W'(sel) : DATA_W'($urandom);
      step(bit'($urandom % 2), a, d, ($urandom % 10) < 6, ($urandom % 4) == 0);
    end
    idle(2);

    // R4 boundary: ack in last allowed cycle succeeds
    doReset();
    step(1, 0, 1, 0, 0);
    idle(TO - 1);
    step(0, 0, 0, 1, 0);
    idle(1);
    regAddr = ADDR_W'(1);
    @(negedge clk); #0.25;
    check("R4 late ack no fatal", regRdData, '0);

    // R4 timeout
    doReset();
    step(1, 0, 1, 0, 0);
    idle(TO);
    idle(1);
    step(1, 0, 3, 0, 0);           // R4 requests blocked
    step(0, 0, 0, 1, 0);
    idle(1);
    @(negedge clk);
    regAddr = ADDR_W'(1); #0.25;
    check("R4 fatal set", regRdData, DATA_W'(3));
    check("R4 no request", DATA_W'(transReq), '0);
    finish();
  end

endmodule